// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block arbitrates a parameterised set of maskable interrupt sources for a small processor core. Each source owns a control entry made of a priority level field and a pending-request bit. A hardware request line sets the pending bit. Software can program the level and clear the pending bit, but it can never set that bit. A single global enable flag gates every source. Requests are weighed against the processor's current priority level, which the core supplies on an input.

The core drives an instruction-boundary strobe. On each strobe the block decides whether to accept an interrupt. When it accepts one, it emits a one-cycle accept pulse carrying the winning source index and level. It holds that index until the core acknowledges the branch to the vector. The acknowledge clears the winner's pending bit.

Changes to the enable flag arrive as commands issued together with the boundary strobe of the instruction that makes the change. The flag-set, flag-clear, pop-flags and load-control commands take effect only from the next instruction boundary. The return-from-interrupt command already applies at its own boundary.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all pending bits and levels are 0, the enable flag is 0, and `acc_pulse` and `acc_pend` are 0.
- R2: A 1 on `src_req[i]` sets pending bit `req_vec[i]` at the next clock edge.
- R3: A software write (`cfg_we`=1) loads `cfg_lvl` into the level of source `cfg_sel`. If `cfg_req` is 0 the write clears that source's pending bit. If `cfg_req` is 1 the write leaves the pending bit unchanged, so it can never be set by software.
- R4: A source is eligible only when its pending bit is 1, its level is nonzero, and its level is strictly greater than `cur_ipl`.
- R5: Among eligible sources the highest level wins. On equal levels the lowest index wins.
- R6: While the effective enable flag is 0 no source is accepted.
- R7: `flag_cmd`=2'b01 (set/clear/pop/load) with `flag_val` loads the flag. The accept decision at the same boundary still uses the old flag value. Later boundaries use the new one.
- R8: `flag_cmd`=2'b10 (return from interrupt) loads the flag with `flag_val`, and the accept decision at that same boundary already uses `flag_val`. Code 2'b00 and code 2'b11 leave the flag unchanged.
- R9: An accept taken at a boundary in cycle t shows `acc_pulse`=1 for exactly one cycle after the edge ending cycle t. `acc_idx` and `acc_lvl` are valid with the pulse. `acc_pend` stays 1 and `acc_idx` stays stable until `irq_ack`. No further accept happens while `acc_pend` is 1.
- R10: `irq_ack` while `acc_pend`=1 clears `acc_pend` and the pending bit of source `acc_idx` at the next edge.
- R11: When `src_req[i]` is 1 in the same cycle as a software clear or an acknowledge clear of source i, the pending bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | N_SRC | Hardware request pulses, one per source |
| cfg_we | input | 1 | Software write strobe to a source control entry |
| cfg_sel | input | IDX_W | Source addressed by the write |
| cfg_lvl | input | LVL_W | Level value written |
| cfg_req | input | 1 | Pending-bit write value (0 clears, 1 no effect) |
| cur_ipl | input | LVL_W | Processor current priority level |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| flag_cmd | input | 2 | Enable-flag command: 00 none, 01 deferred update, 10 return update |
| flag_val | input | 1 | New enable-flag value for a command |
| irq_ack | input | 1 | Core acknowledge of the accepted interrupt |
| acc_pulse | output | 1 | One-cycle accept pulse |
| acc_idx | output | IDX_W | Accepted source index |
| acc_lvl | output | LVL_W | Accepted source level |
| acc_pend | output | 1 | Accepted interrupt awaiting acknowledge |
| ien | output | 1 | Stored global enable flag |
| req_vec | output | N_SRC | Pending bits of all sources |

## Verification
The assertions assume that the core raises `irq_ack` only while `acc_pend` is 1, and that flag commands arrive in the same cycle as a boundary strobe. The directed stimulus respects both rules. Every acknowledge is issued only after an observed accept, and every flag command is bundled with `insn_bnd`. Priority contests are built by loading levels first and raising requests afterwards, so each boundary decision sees a settled set of pending bits.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    FCMD_NONE  = 2'b00,
    FCMD_DEFER = 2'b01,
    FCMD_RET   = 2'b10,
    FCMD_RSVD  = 2'b11
  } flag_cmd_e;

  // eligibility rule: pending, enabled level, strictly above processor level
  function automatic logic src_eligible(input logic pend, input logic [7:0] lvl,
                                        input logic [7:0] ipl);
    return pend && (lvl != 8'd0) && (lvl > ipl);
  endfunction
endpackage

// File: rtl/irq_src_entry.sv
module irq_src_entry #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_set,
  input  logic             sw_we,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             sw_req,
  input  logic             ack_clr,
  output logic             pend,
  output logic [LVL_W-1:0] lvl
);
  logic sw_clr;
  assign sw_clr = sw_we && !sw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      lvl  <= '0;
    end else begin
      if (hw_set)                  pend <= 1'b1;
      else if (sw_clr || ack_clr)  pend <= 1'b0;
      if (sw_we)                   lvl  <= sw_lvl;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]            pend_vec,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_vec,
  input  logic [LVL_W-1:0]            ipl,
  output logic                        any_elig,
  output logic [IDX_W-1:0]            win_idx,
  output logic [LVL_W-1:0]            win_lvl
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = src_eligible(pend_vec[g], 8'(lvl_vec[g]), 8'(ipl));
  end

  always_comb begin
    any_elig = 1'b0;
    win_idx  = '0;
    win_lvl  = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!any_elig || lvl_vec[i] > win_lvl)) begin
        any_elig = 1'b1;
        win_idx  = IDX_W'(i);
        win_lvl  = lvl_vec[i];
      end
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  input  logic       val,
  output logic       ien_q,
  output logic       ien_eff
);
  logic loads;
  assign loads = (cmd == FCMD_DEFER) || (cmd == FCMD_RET);

  // a return update already counts at its own boundary
  assign ien_eff = (cmd == FCMD_RET) ? val : ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ien_q <= 1'b0;
    else if (loads) ien_q <= val;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_sel,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             cfg_req,
  input  logic [LVL_W-1:0] cur_ipl,
  input  logic             insn_bnd,
  input  logic [1:0]       flag_cmd,
  input  logic             flag_val,
  input  logic             irq_ack,
  output logic             acc_pulse,
  output logic [IDX_W-1:0] acc_idx,
  output logic [LVL_W-1:0] acc_lvl,
  output logic             acc_pend,
  output logic             ien,
  output logic [N_SRC-1:0] req_vec
);
  logic [N_SRC-1:0][LVL_W-1:0] lvl_vec;
  logic                        ien_eff;
  logic                        any_elig;
  logic [IDX_W-1:0]            win_idx;
  logic [LVL_W-1:0]            win_lvl;
  logic                        take;
  logic                        ack_fire;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic sel_hit;
    assign sel_hit = cfg_we && (cfg_sel == IDX_W'(g));
    irq_src_entry #(.LVL_W(LVL_W)) ent_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (src_req[g]),
      .sw_we   (sel_hit),
      .sw_lvl  (cfg_lvl),
      .sw_req  (cfg_req),
      .ack_clr (ack_fire && (acc_idx == IDX_W'(g))),
      .pend    (req_vec[g]),
      .lvl     (lvl_vec[g])
    );
  end

  irq_flag_ctrl flag_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (flag_cmd),
    .val     (flag_val),
    .ien_q   (ien),
    .ien_eff (ien_eff)
  );

  irq_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) arb_i (
    .pend_vec (req_vec),
    .lvl_vec  (lvl_vec),
    .ipl      (cur_ipl),
    .any_elig (any_elig),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign take     = insn_bnd && ien_eff && any_elig && !acc_pend;
  assign ack_fire = irq_ack && acc_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_pulse <= 1'b0;
      acc_pend  <= 1'b0;
      acc_idx   <= '0;
      acc_lvl   <= '0;
    end else begin
      acc_pulse <= take;
      if (take) begin
        acc_pend <= 1'b1;
        acc_idx  <= win_idx;
        acc_lvl  <= win_lvl;
      end else if (ack_fire) begin
        acc_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_req,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_sel,
  input logic             cfg_req,
  input logic [LVL_W-1:0] cur_ipl,
  input logic             insn_bnd,
  input logic [1:0]       flag_cmd,
  input logic             irq_ack,
  input logic             acc_pulse,
  input logic [IDX_W-1:0] acc_idx,
  input logic [LVL_W-1:0] acc_lvl,
  input logic             acc_pend,
  input logic             ien,
  input logic [N_SRC-1:0] req_vec
);
  AST_SET_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    src_req[0] |=> req_vec[0]); // R2

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_req && !req_vec[cfg_sel] && !src_req[cfg_sel])
      |=> !req_vec[$past(cfg_sel)]); // R3

  AST_ACC_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> (acc_lvl > $past(cur_ipl)) && (acc_lvl != '0)); // R4

  AST_DEFER_OLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_bnd && flag_cmd == 2'b01 && !ien) |=> !acc_pulse); // R7

  AST_ACC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> $past(insn_bnd) && acc_pend); // R9

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |=> !acc_pulse); // R9

  AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pend && !irq_ack) |=> acc_pend && $stable(acc_idx)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && acc_pend && !src_req[acc_idx])
      |=> !acc_pend && !req_vec[$past(acc_idx)]); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_SRC(N_SRC), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_req(cfg_req), .cur_ipl(cur_ipl), .insn_bnd(insn_bnd), .flag_cmd(flag_cmd),
  .irq_ack(irq_ack), .acc_pulse(acc_pulse), .acc_idx(acc_idx), .acc_lvl(acc_lvl),
  .acc_pend(acc_pend), .ien(ien), .req_vec(req_vec)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam int N = 8;
  localparam int LW = 3;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_sel = '0;
  logic [LW-1:0] cfg_lvl = '0;
  logic          cfg_req = 1'b1;
  logic [LW-1:0] cur_ipl = '0;
  logic          insn_bnd = 1'b0;
  logic [1:0]    flag_cmd = 2'b00;
  logic          flag_val = 1'b0;
  logic          irq_ack = 1'b0;
  logic          acc_pulse, acc_pend, ien;
  logic [IW-1:0] acc_idx;
  logic [LW-1:0] acc_lvl;
  logic [N-1:0]  req_vec;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(N), .LVL_W(LW)) dut_i (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; src_req = '0; cfg_we = 0; insn_bnd = 0; flag_cmd = 0; irq_ack = 0;
    cur_ipl = '0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic wr(input int idx, input int lvl, input logic rq);
    cfg_we = 1; cfg_sel = IW'(idx); cfg_lvl = LW'(lvl); cfg_req = rq;
    cyc();
    cfg_we = 0; cfg_req = 1;
  endtask

  task automatic raise(input int idx);
    src_req[idx] = 1'b1; cyc(); src_req = '0;
  endtask

  // boundary strobe with optional flag command; outputs at return reflect that decision
  task automatic bnd(input logic [1:0] cmd, input logic v);
    insn_bnd = 1; flag_cmd = cmd; flag_val = v;
    cyc();
    insn_bnd = 0; flag_cmd = 2'b00;
  endtask

  task automatic ack();
    irq_ack = 1; cyc(); irq_ack = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(req_vec == '0, "R1 req_vec", int'(req_vec), 0);
    chk(!acc_pulse && !acc_pend, "R1 accept idle", int'(acc_pend), 0);
    chk(ien == 0, "R1 flag", int'(ien), 0);
    bnd(2'b00, 0);  // levels are 0, flag 0: nothing accepted
    chk(!acc_pulse, "R1 no accept", int'(acc_pulse), 0);
  endtask

  task automatic t_defer_and_ack();
    do_reset();
    wr(3, 5, 1);
    raise(3);
    chk(req_vec[3] == 1, "R2 set", int'(req_vec[3]), 1);
    bnd(2'b00, 0);
    chk(!acc_pulse, "R6 flag 0 blocks", int'(acc_pulse), 0);
    bnd(2'b01, 1);
    chk(!acc_pulse && ien, "R7 old flag at own boundary", int'(acc_pulse), 0);
    bnd(2'b00, 0);
    chk(acc_pulse && acc_idx == 3 && acc_lvl == 5, "R7 new flag next boundary",
        int'(acc_idx), 3);
    cyc();
    chk(!acc_pulse && acc_pend, "R9 pulse one cycle", int'(acc_pulse), 0);
    ack();
    chk(!acc_pend && !req_vec[3], "R10 ack clears", int'(req_vec[3]), 0);
    // deferred clear: its own boundary still accepts
    raise(3);
    bnd(2'b01, 0);
    chk(acc_pulse, "R7 deferred clear still old", int'(acc_pulse), 1);
    ack();
    raise(3);
    bnd(2'b00, 0);
    chk(!acc_pulse, "R7 cleared flag later", int'(acc_pulse), 0);
  endtask

  task automatic t_return();
    do_reset();
    wr(1, 4, 1);
    raise(1);
    bnd(2'b10, 1);
    chk(acc_pulse && acc_idx == 1, "R8 return applies same boundary", int'(acc_pulse), 1);
    ack();
    raise(1);
    bnd(2'b10, 0);
    chk(!acc_pulse && !ien, "R8 return clear same boundary", int'(acc_pulse), 0);
    bnd(2'b11, 1);
    chk(ien == 0 && !acc_pulse, "R8 code 11 ignored", int'(ien), 0);
  endtask

  task automatic t_prio();
    do_reset();
    bnd(2'b01, 1);
    wr(2, 3, 1); wr(5, 6, 1); wr(6, 6, 1); wr(0, 0, 1);
    src_req = 8'b0110_0101; cyc(); src_req = '0;
    cur_ipl = 3'd6;
    bnd(2'b00, 0);
    chk(!acc_pulse, "R4 strictly above ipl", int'(acc_pulse), 0);
    cur_ipl = 3'd0;
    bnd(2'b00, 0);
    chk(acc_pulse && acc_idx == 5 && acc_lvl == 6, "R5 tie lowest index", int'(acc_idx), 5);
    // higher source appears while pending: no new accept, index held
    wr(7, 7, 1); raise(7);
    bnd(2'b00, 0);
    chk(!acc_pulse && acc_idx == 5, "R9 hold while pending", int'(acc_idx), 5);
    ack();
    bnd(2'b00, 0);
    chk(acc_pulse && acc_idx == 7 && acc_lvl == 7, "R5 highest level", int'(acc_idx), 7);
    ack();
    bnd(2'b00, 0);
    chk(acc_pulse && acc_idx == 6, "R5 next after ack", int'(acc_idx), 6);
    ack(); bnd(2'b00, 0); ack();
    chk(req_vec == 8'b0000_0001, "R4 level 0 left pending", int'(req_vec), 1);
    bnd(2'b00, 0);
    chk(!acc_pulse, "R4 level 0 never accepted", int'(acc_pulse), 0);
  endtask

  task automatic t_sw_and_race();
    do_reset();
    wr(4, 2, 1);
    chk(req_vec[4] == 0, "R3 write 1 no set", int'(req_vec[4]), 0);
    raise(4);
    wr(4, 2, 0);
    chk(req_vec[4] == 0, "R3 write 0 clears", int'(req_vec[4]), 0);
    src_req[4] = 1; cfg_we = 1; cfg_sel = 3'd4; cfg_lvl = 3'd2; cfg_req = 0;
    cyc();
    src_req = '0; cfg_we = 0; cfg_req = 1;
    chk(req_vec[4] == 1, "R11 request beats sw clear", int'(req_vec[4]), 1);
    bnd(2'b10, 1);
    chk(acc_pulse && acc_idx == 4 && acc_lvl == 2, "R3 level written", int'(acc_lvl), 2);
    src_req[4] = 1; irq_ack = 1; cyc(); src_req = '0; irq_ack = 0;
    chk(req_vec[4] == 1 && !acc_pend, "R11 request beats ack clear", int'(req_vec[4]), 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_defer_and_ack();
        t_return();
        t_prio();
        t_sw_and_race();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule